// File: doc/BRIEF.md
# Indirect register access bridge

This block gives a host a small four-register window through which it reaches a separate 32-bit internal register space. To write an internal register, the host loads the operand and the target address, then sets a write request in the command register. To read, it loads the address and sets a read request. The bridge then runs one transfer on a request/acknowledge internal bus and keeps the request asserted until the slave answers. It stores returned read data and raises an acknowledge flag in the command register. The host polls for that flag, collects any read data, and writes zero to the command register. That write returns the bridge to idle.

Each internal access therefore takes two host-visible phases: a launch and a clear. The internal space uses byte addresses on a stride of four, across 4 KiB (0x000 to 0xFFF). The host window sits at base 0x400 of the host address map by default.

The state machine has three states. IDLE accepts a command. BUSY holds the internal request. DONE holds the acknowledge until the host clears it. The transitions are:
- IDLE to BUSY on a single read or a single write request.
- IDLE to DONE on a request with both bits set, which is a no-op.
- BUSY to DONE on the internal acknowledge.
- DONE to IDLE on a command write with both request bits zero.
- Any state to IDLE on reset.

Top module: `ind_reg_bridge`

## Requirements
- R1: A synchronous active-high reset returns the bridge to IDLE with `ib_req` low, and every window register reads zero afterwards, even if reset arrives mid-transfer.
- R2: Host accesses decode as follows, relative to `WIN_BASE` (0x400): word offset 0x0 is the command register, 0x4 the address register, 0x8 the read-data register and 0xC the write-data register. An access outside the window, or with address bits [1:0] non-zero, reads as zero and its write is ignored.
- R3: The command register reads back bit 0 as the pending or completed read request, bit 1 as the write request and bit 2 as the acknowledge flag; all higher bits read zero.
- R4: Writing 0x2 to the command register in IDLE issues one internal write carrying the address and write-data registers. When the slave acknowledges, the command register reads 0x6.
- R5: Writing 0x1 to the command register in IDLE issues one internal read with `ib_we` low. When the slave acknowledges, the read-data register holds the returned word and the command register reads 0x5.
- R6: `ib_req` stays high, with `ib_we`, `ib_addr` and `ib_wdata` unchanged, until the cycle in which `ib_ack` is seen, whatever the slave latency. It is low in every cycle after that until a new command.
- R7: In DONE, writing a command with bits [1:0] zero returns the command register to 0 and the bridge to IDLE. A zero command in BUSY does not abort the transfer.
- R8: Request bits written to the command register while BUSY or DONE are ignored: no new internal access starts and the readback does not change.
- R9: A command with both bits 0 and 1 set performs no internal access and reads back 0x7 in the very next cycle.
- R10: Host writes to the address and write-data registers are ignored while BUSY.
- R11: The address register keeps 12 bits as written, but `ib_addr` always carries bits [1:0] as zero, giving word-aligned internal accesses.
- R12: The read-data register cannot be written by the host; only a completed internal read changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HAW (12) | Host byte address |
| host_wdata | input | DW (32) | Host write data |
| host_rdata | output | DW (32) | Combinational read data for `host_addr` |
| ib_req | output | 1 | Internal bus request, held until acknowledge |
| ib_we | output | 1 | Internal bus direction, 1 = write |
| ib_addr | output | IAW (12) | Internal byte address, word aligned |
| ib_wdata | output | DW (32) | Internal write data |
| ib_ack | input | 1 | One-cycle acknowledge from the internal slave |
| ib_rdata | input | DW (32) | Internal read data, valid with `ib_ack` |

## Verification
The bench varies the slave latency from zero to twenty cycles. A bridge that dropped or re-issued its request early would then either lose the transfer or write twice, which shows up as a bus mismatch or a wrong access count. It sends request bits and operand writes while a transfer is in flight and while the acknowledge is pending. A design without that protection would start a second access, change `ib_addr` mid-request, or alter the readback. Three further cases are covered:
- A both-bits no-op, which a careless design would send to the bus.
- A misaligned address, where the low bits would otherwise leak onto `ib_addr`.
- A reset that lands inside a long transfer and must leave every register at zero.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } br_state_t;

    // word index of each window register (host byte offset >> 2)
    localparam logic [1:0] WOFF_CMD   = 2'd0;
    localparam logic [1:0] WOFF_ADDR  = 2'd1;
    localparam logic [1:0] WOFF_RDATA = 2'd2;
    localparam logic [1:0] WOFF_WDATA = 2'd3;

    // command register bit positions
    localparam int CMD_RD_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_ACK_BIT = 2;

endpackage

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_we,
    input  logic [1:0] cmd_req,
    input  logic       ib_ack,
    output br_state_t  state,
    output logic       req_rd,
    output logic       req_wr,
    output logic       ack_flag,
    output logic       ib_req,
    output logic       ib_we,
    output logic       rd_capture
);

    br_state_t next_state;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next_state;
    end

    // transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_we) begin
                    if (cmd_req == 2'b11)      next_state = ST_DONE;
                    else if (cmd_req != 2'b00) next_state = ST_BUSY;
                end
            end
            ST_BUSY: if (ib_ack) next_state = ST_DONE;
            ST_DONE: if (cmd_we && cmd_req == 2'b00) next_state = ST_IDLE;
            default: next_state = ST_IDLE;
        endcase
    end

    // latched request bits, live in the command readback
    always_ff @(posedge clk) begin
        if (rst) begin
            req_rd <= 1'b0;
            req_wr <= 1'b0;
        end else if (state == ST_IDLE && cmd_we && cmd_req != 2'b00) begin
            req_rd <= cmd_req[0];
            req_wr <= cmd_req[1];
        end else if (state == ST_DONE && cmd_we && cmd_req == 2'b00) begin
            req_rd <= 1'b0;
            req_wr <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ib_req     = (state == ST_BUSY);
        ib_we      = req_wr;
        ack_flag   = (state == ST_DONE);
        rd_capture = (state == ST_BUSY) && ib_ack && req_rd;
    end

    // R1: reset leaves the machine idle
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (state == ST_IDLE && !ib_req));

    // R6: request holds until the acknowledge arrives
    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ack) |=> ib_req);

    // R6: request drops after the acknowledge
    a_r6_req_drop: assert property (@(posedge clk) disable iff (rst)
        (ib_req && ib_ack) |=> (!ib_req && ack_flag));

    // R7: zero command in DONE clears everything
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (ack_flag && cmd_we && cmd_req == 2'b00) |=> (!ack_flag && !req_rd && !req_wr));

    // R8: no new request while the acknowledge is pending
    a_r8_no_req_in_done: assert property (@(posedge clk) disable iff (rst)
        ack_flag |-> !ib_req);

    // R9: both bits set acknowledges at once without a bus request
    a_r9_noop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cmd_we && cmd_req == 2'b11) |=> (ack_flag && !ib_req));

endmodule

// File: rtl/bridge_win_regs.sv
module bridge_win_regs #(
    parameter int DW  = 32,
    parameter int IAW = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic           addr_we,
    input  logic           wdata_we,
    input  logic [DW-1:0]  host_wdata,
    input  logic           rd_capture,
    input  logic [DW-1:0]  ib_rdata,
    output logic [IAW-1:0] addr_q,
    output logic [DW-1:0]  wdata_q,
    output logic [DW-1:0]  rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (addr_we && !hold)  addr_q  <= host_wdata[IAW-1:0];
            if (wdata_we && !hold) wdata_q <= host_wdata;
            if (rd_capture)        rdata_q <= ib_rdata;
        end
    end

    // R10: operands frozen while the transfer is in flight
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(addr_q) && $stable(wdata_q)));

    // R12: read data changes only on a captured internal read
    a_r12_rdata_src: assert property (@(posedge clk) disable iff (rst)
        !rd_capture |=> $stable(rdata_q));

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import bridge_pkg::*;
#(
    parameter int             DW       = 32,
    parameter int             IAW      = 12,
    parameter int             HAW      = 12,
    parameter logic [HAW-1:0] WIN_BASE = 12'h400
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_wr,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata,
    output logic           ib_req,
    output logic           ib_we,
    output logic [IAW-1:0] ib_addr,
    output logic [DW-1:0]  ib_wdata,
    input  logic           ib_ack,
    input  logic [DW-1:0]  ib_rdata
);

    localparam logic [HAW-5:0] WIN_TAG = WIN_BASE[HAW-1:4];

    logic           hit;
    logic [1:0]     woff;
    logic           cmd_we, addr_we, wdata_we;
    br_state_t      state;
    logic           req_rd, req_wr, ack_flag, rd_capture;
    logic [IAW-1:0] addr_q;
    logic [DW-1:0]  wdata_q, rdata_q;

    // window decode: aligned accesses inside the 16-byte window only
    always_comb begin
        hit      = (host_addr[HAW-1:4] == WIN_TAG) && (host_addr[1:0] == 2'b00);
        woff     = host_addr[3:2];
        cmd_we   = host_wr && hit && (woff == WOFF_CMD);
        addr_we  = host_wr && hit && (woff == WOFF_ADDR);
        wdata_we = host_wr && hit && (woff == WOFF_WDATA);
    end

    bridge_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_we     (cmd_we),
        .cmd_req    (host_wdata[1:0]),
        .ib_ack     (ib_ack),
        .state      (state),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .ack_flag   (ack_flag),
        .ib_req     (ib_req),
        .ib_we      (ib_we),
        .rd_capture (rd_capture)
    );

    bridge_win_regs #(.DW(DW), .IAW(IAW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .hold       (state == ST_BUSY),
        .addr_we    (addr_we),
        .wdata_we   (wdata_we),
        .host_wdata (host_wdata),
        .rd_capture (rd_capture),
        .ib_rdata   (ib_rdata),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .rdata_q    (rdata_q)
    );

    // internal bus operands, word aligned
    always_comb begin
        ib_addr  = {addr_q[IAW-1:2], 2'b00};
        ib_wdata = wdata_q;
    end

    // host read mux
    always_comb begin
        host_rdata = '0;
        if (hit) begin
            unique case (woff)
                WOFF_CMD: begin
                    host_rdata[CMD_RD_BIT]  = req_rd;
                    host_rdata[CMD_WR_BIT]  = req_wr;
                    host_rdata[CMD_ACK_BIT] = ack_flag;
                end
                WOFF_ADDR:  host_rdata[IAW-1:0] = addr_q;
                WOFF_RDATA: host_rdata = rdata_q;
                WOFF_WDATA: host_rdata = wdata_q;
                default:    host_rdata = '0;
            endcase
        end
    end

    // R6: bus operands stable across a pending request
    a_r6_operands_stable: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ack) |=> ($stable(ib_addr) && $stable(ib_wdata) && $stable(ib_we)));

    // R11: internal address always word aligned
    a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
        ib_req |-> (ib_addr[1:0] == 2'b00));

    // R3: only the three defined command bits can ever read as one
    a_r3_cmd_bits: assert property (@(posedge clk) disable iff (rst)
        (hit && woff == WOFF_CMD) |-> (host_rdata[DW-1:3] == '0));

endmodule

// File: tb/ind_reg_bridge_test.sv
`timescale 1ns/100ps
module ind_reg_bridge_test;

    localparam logic [11:0] A_CMD = 12'h400, A_ADR = 12'h404, A_RD = 12'h408, A_WD = 12'h40C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ib_req, ib_we;
    logic [11:0] ib_addr;
    logic [31:0] ib_wdata;
    logic        ib_ack = 1'b0;
    logic [31:0] ib_rdata = '0;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int scnt = 0;
    int accesses = 0;
    int cycles = 0;

    logic [31:0] mem [0:1023];

    // reference model state
    logic        m_busy = 0, m_ack = 0, m_rd = 0, m_wr = 0;
    logic [11:0] m_addr = '0;
    logic [31:0] m_wd = '0, m_rdv = '0;

    ind_reg_bridge uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ib_req(ib_req),
        .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_ack(ib_ack), .ib_rdata(ib_rdata)
    );

    always #2.5 clk = ~clk;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_0000 ^ i;
        mem[0] = 32'h0000_0A15;   // build version
        mem[1] = 32'h0102_0304;   // firmware version
        mem[8] = 32'h1122_3344;   // MAC low word
        mem[9] = 32'h0008_5566;   // MAC high word, count 8 in [23:16]
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a[11:4] != 8'h40 || a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return {29'h0, m_ack, m_wr, m_rd};
            2'd1: return {20'h0, m_addr};
            2'd2: return m_rdv;
            default: return m_wd;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // slave with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            ib_ack <= 1'b0;
            scnt <= 0;
        end else if (ib_ack) begin
            ib_ack <= 1'b0;
        end else if (ib_req) begin
            if (scnt >= lat) begin
                ib_ack <= 1'b1;
                scnt <= 0;
                accesses <= accesses + 1;
                if (ib_we) mem[ib_addr[11:2]] <= ib_wdata;
                else       ib_rdata <= mem[ib_addr[11:2]];
            end else begin
                scnt <= scnt + 1;
            end
        end
    end

    // reference model
    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_ack <= 0; m_rd <= 0; m_wr <= 0;
            m_addr <= '0; m_wd <= '0; m_rdv <= '0;
        end else begin
            if (host_wr && host_addr[11:4] == 8'h40 && host_addr[1:0] == 2'b00) begin
                case (host_addr[3:2])
                    2'd0: begin
                        if (!m_busy && !m_ack) begin
                            if (host_wdata[1:0] == 2'b11) begin
                                m_ack <= 1; m_rd <= 1; m_wr <= 1;
                            end else if (host_wdata[1:0] != 2'b00) begin
                                m_busy <= 1; m_rd <= host_wdata[0]; m_wr <= host_wdata[1];
                            end
                        end else if (m_ack && host_wdata[1:0] == 2'b00) begin
                            m_ack <= 0; m_rd <= 0; m_wr <= 0;
                        end
                    end
                    2'd1: if (!m_busy) m_addr <= host_wdata[11:0];
                    2'd3: if (!m_busy) m_wd <= host_wdata;
                    default: ;
                endcase
            end
            if (m_busy && ib_ack) begin
                m_busy <= 0;
                m_ack <= 1;
                if (m_rd) m_rdv <= ib_rdata;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R6 ib_req", {31'h0, ib_req}, {31'h0, m_busy});
            if (m_busy) begin
                check("R6 ib_we", {31'h0, ib_we}, {31'h0, m_wr});
                check("R11 ib_addr", {20'h0, ib_addr}, {20'h0, m_addr[11:2], 2'b00});
                check("R6 ib_wdata", ib_wdata, m_wd);
            end
            check("R2 host_rdata", host_rdata, m_read(host_addr));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic wait_ack();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            host_addr = A_CMD;
            #1;
            if (host_rdata[2]) break;
        end
    endtask

    task automatic do_read(input logic [11:0] a, input int l, input logic [31:0] exp, input string tag);
        lat = l;
        hwrite(A_ADR, {20'h0, a});
        hwrite(A_CMD, 32'h1);
        wait_ack();
        hread(A_CMD, 32'h5, tag);
        hread(A_RD, exp, tag);
        hwrite(A_CMD, 32'h0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        hread(A_CMD, 32'h0, "R1 cmd");
        hread(A_ADR, 32'h0, "R1 addr");
        hread(A_RD, 32'h0, "R1 rdata");
        hread(A_WD, 32'h0, "R1 wdata");
        check("R1 ib_req", {31'h0, ib_req}, 32'h0);

        // R4: write transaction, zero latency
        lat = 0;
        base = accesses;
        hwrite(A_WD, 32'hDEAD_BEEF);
        hwrite(A_ADR, 32'h30);
        hwrite(A_CMD, 32'h2);
        wait_ack();
        hread(A_CMD, 32'h6, "R4 cmd ack");
        check("R4 mem", mem[12], 32'hDEAD_BEEF);
        check("R4 one access", accesses - base, 1);
        hwrite(A_CMD, 32'h0);
        hread(A_CMD, 32'h0, "R7 cleared");

        // R5, R8, R10: read with latency, interference while busy
        lat = 6;
        base = accesses;
        hwrite(A_ADR, 32'h24);
        hwrite(A_CMD, 32'h1);
        hwrite(A_CMD, 32'h2);          // R8 ignored
        hwrite(A_CMD, 32'h0);          // R7 no abort in BUSY
        hwrite(A_ADR, 32'h0);          // R10 ignored
        hwrite(A_WD, 32'h1234_5678);   // R10 ignored
        hread(A_ADR, 32'h24, "R10 addr frozen");
        hread(A_WD, 32'hDEAD_BEEF, "R10 wdata frozen");
        wait_ack();
        hread(A_CMD, 32'h5, "R5 cmd ack");
        hread(A_RD, 32'h0008_5566, "R5 mac high");
        hwrite(A_CMD, 32'h1);          // R8 ignored while ack set
        repeat (4) @(negedge clk);
        hread(A_CMD, 32'h5, "R8 cmd unchanged");
        check("R8 one access", accesses - base, 1);
        hwrite(A_CMD, 32'h0);
        hread(A_CMD, 32'h0, "R7 cleared after read");

        // R5 further reads at other latencies
        do_read(12'h000, 1, 32'h0000_0A15, "R5 build");
        do_read(12'h004, 3, 32'h0102_0304, "R5 firmware");
        do_read(12'h020, 20, 32'h1122_3344, "R6 long latency");

        // R9: no-op
        base = accesses;
        hwrite(A_CMD, 32'h3);
        hread(A_CMD, 32'h7, "R9 noop ack");
        repeat (3) @(negedge clk);
        check("R9 no access", accesses - base, 0);
        hwrite(A_CMD, 32'h0);
        hread(A_CMD, 32'h0, "R9 cleared");

        // R11: misaligned address
        hread(A_ADR, 32'h20, "R11 pre");
        hwrite(A_ADR, 32'h33);
        hread(A_ADR, 32'h33, "R11 stored");
        lat = 2;
        hwrite(A_CMD, 32'h1);
        wait_ack();
        hread(A_RD, 32'hDEAD_BEEF, "R11 aligned read");
        hwrite(A_CMD, 32'h0);

        // R12: read data not writable
        hwrite(A_RD, 32'h5555_AAAA);
        hread(A_RD, 32'hDEAD_BEEF, "R12 rdata kept");

        // R2: outside window and misaligned host access
        hwrite(12'h000, 32'h2);
        hwrite(12'h401, 32'h2);
        hread(A_CMD, 32'h0, "R2 no command");
        hread(12'h100, 32'h0, "R2 outside reads zero");
        hread(A_WD, 32'hDEAD_BEEF, "R2 wdata offset");

        // R1: reset during a long transfer
        lat = 30;
        hwrite(A_ADR, 32'h8);
        hwrite(A_CMD, 32'h1);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hread(A_CMD, 32'h0, "R1 cmd after reset");
        hread(A_ADR, 32'h0, "R1 addr after reset");
        hread(A_RD, 32'h0, "R1 rdata after reset");
        check("R1 req after reset", {31'h0, ib_req}, 32'h0);

        repeat (5) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule